// File: doc/BRIEF.md
# Pairwise Task Load Balancer

This block evens out the number of pending tasks held by each of N nodes. A pulse on `start` captures one task count per node. The block adds the counts and takes the per-node average, which is the sum divided by N with the remainder dropped. It then runs a sequence of rounds, one round per clock. In each round, every node that is paired this round hands exactly one task to a partner node. The block stops when the counts of any two nodes differ by at most one task.

Each round is reported on a set of transfer slots. Every slot carries a source node index, a destination node index and a valid bit. `count_out` shows the updated counts in the same cycle as the transfers of that round. A migration network outside this block can replay the slot stream to move the real tasks.

Balancing runs in two phases:
- **Spreading phase.** A node above the average gives tasks and a node below it takes them.
- **Trimming phase.** This phase runs only when a node is still two or more tasks above the average. A node exactly at the average may take one task. A node one above the average sits out. A node further above keeps giving tasks until it is one above the average.

Top module: `lb_balancer`

## Requirements
- R1: After reset, `done`, `busy` and all bits of `xfer_vld` are 0, and `count_out` is all zeros.
- R2: After a run, `avg_out` equals the floor of the sum of the captured counts divided by N.
- R3: In the spreading phase (`xfer_redist` = 0), every source slot names a node whose count is above the average and every destination slot names a node below it. Nodes at the average are never named.
- R4: The number of valid slots in a round equals the smaller of the giver count and the taker count under that phase's classification. A round with no valid slot is never reported.
- R5: Valid slots are packed from slot 0 upward. Slot k pairs the k-th lowest-index giver with the k-th lowest-index taker. Slot k occupies bits [k*IW +: IW] of `xfer_src` and `xfer_dst`. Invalid slots read as index 0.
- R6: In the cycle a round is reported, `count_out` shows each source node one lower and each destination node one higher than before the round. The sum of all counts is preserved.
- R7: The trimming phase (`xfer_redist` = 1) runs only if some node is at least two above the average when spreading ends. In trimming, givers are nodes more than one above the average and takers are nodes exactly at the average.
- R8: When balancing ends, `done` rises and stays high until the next accepted `start`. `busy` is then 0, and every count lies between the average and the average plus one.
- R9: A `start` pulse while `busy` is high is ignored: the run in progress completes with the original counts.
- R10: Within one valid slot, the source and destination node differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture `load_in` and begin a run (ignored while busy) |
| load_in | input | N*CW | Initial task count of node i at bits [i*CW +: CW] |
| xfer_vld | output | P | Per-slot transfer valid, P = N/2 |
| xfer_src | output | P*IW | Source node index per slot |
| xfer_dst | output | P*IW | Destination node index per slot |
| xfer_redist | output | 1 | 1 when the reported round belongs to the trimming phase |
| busy | output | 1 | Run in progress |
| done | output | 1 | Balancing complete |
| count_out | output | N*CW | Current count of node i at bits [i*CW +: CW] |
| avg_out | output | CW | Floor of the captured sum divided by N |

## Verification
The checker assumes that the sum of the captured counts fits the internal total width, so that the average and the task-conservation property are exact. It also assumes that `start` may arrive in any state, since the block must tolerate it while busy.

The stimulus keeps every count within CW bits and includes these cases:
- all-zero and all-equal loads;
- a single node holding every task, which drives a long trimming phase;
- two nodes at the maximum count;
- a mixed load.

One run repeats `start` with different counts partway through, to show that the run in progress is unaffected.

// File: rtl/lb_pkg.sv
package lb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SUM    = 3'd1,
        ST_DIST   = 3'd2,
        ST_REDIST = 3'd3,
        ST_DONE   = 3'd4
    } lb_state_e;
endpackage

// File: rtl/lb_total.sv
module lb_total #(
    parameter int N  = 8,
    parameter int CW = 8,
    parameter int TW = 11
) (
    input  logic [N*CW-1:0] cnt,
    output logic [TW-1:0]   total
);
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + TW'(cnt[i*CW +: CW]);
        end
    end
endmodule

// File: rtl/lb_classify.sv
module lb_classify #(
    parameter int N  = 8,
    parameter int CW = 8
) (
    input  logic [N*CW-1:0] cnt,
    input  logic [CW-1:0]   avg,
    input  logic            redist,
    output logic [N-1:0]    giver,
    output logic [N-1:0]    taker,
    output logic [N-1:0]    surplus2
);
    localparam int DW = CW + 2;
    localparam logic signed [DW-1:0] ZERO = '0;
    localparam logic signed [DW-1:0] ONE  = DW'(1);

    for (genvar g = 0; g < N; g++) begin : g_node
        logic signed [DW-1:0] delta;
        assign delta = $signed({2'b00, cnt[g*CW +: CW]}) - $signed({2'b00, avg});
        assign giver[g]    = redist ? (delta > ONE)   : (delta > ZERO);
        assign taker[g]    = redist ? (delta == ZERO) : (delta < ZERO);
        assign surplus2[g] = (delta > ONE);
    end
endmodule

// File: rtl/lb_pair.sv
module lb_pair #(
    parameter int N    = 8,
    parameter int P    = 4,
    parameter int IW   = 3,
    parameter int CNTW = 4
) (
    input  logic [N-1:0]    giver,
    input  logic [N-1:0]    taker,
    output logic [P-1:0]    slot_vld,
    output logic [P*IW-1:0] slot_src,
    output logic [P*IW-1:0] slot_dst,
    output logic [N-1:0]    send_mask,
    output logic [N-1:0]    recv_mask
);
    logic [CNTW-1:0] n_give, n_take, width;
    logic [CNTW-1:0] r_give, r_take;

    always_comb begin
        n_give   = '0;
        n_take   = '0;
        slot_src = '0;
        slot_dst = '0;
        for (int i = 0; i < N; i++) begin
            for (int k = 0; k < P; k++) begin
                if (giver[i] && n_give == CNTW'(k)) slot_src[k*IW +: IW] = IW'(i);
                if (taker[i] && n_take == CNTW'(k)) slot_dst[k*IW +: IW] = IW'(i);
            end
            if (giver[i]) n_give = n_give + 1'b1;
            if (taker[i]) n_take = n_take + 1'b1;
        end
        width = (n_give < n_take) ? n_give : n_take;
        for (int k = 0; k < P; k++) begin
            slot_vld[k] = (CNTW'(k) < width);
            if (!slot_vld[k]) begin
                slot_src[k*IW +: IW] = '0;
                slot_dst[k*IW +: IW] = '0;
            end
        end
        r_give = '0;
        r_take = '0;
        for (int i = 0; i < N; i++) begin
            send_mask[i] = giver[i] && (r_give < width);
            recv_mask[i] = taker[i] && (r_take < width);
            if (giver[i]) r_give = r_give + 1'b1;
            if (taker[i]) r_take = r_take + 1'b1;
        end
    end
endmodule

// File: rtl/lb_balancer.sv
module lb_balancer
    import lb_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = 8,
    parameter int P  = N / 2,
    parameter int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [N*CW-1:0] load_in,
    output logic [P-1:0]    xfer_vld,
    output logic [P*IW-1:0] xfer_src,
    output logic [P*IW-1:0] xfer_dst,
    output logic            xfer_redist,
    output logic            busy,
    output logic            done,
    output logic [N*CW-1:0] count_out,
    output logic [CW-1:0]   avg_out
);
    localparam int LOG2N = $clog2(N);
    localparam int TW    = CW + LOG2N;
    localparam int CNTW  = $clog2(N + 1);

    typedef struct packed {
        lb_state_e        st;
        logic [N*CW-1:0]  cnt;
        logic [CW-1:0]    avg;
        logic [P-1:0]     vld;
        logic [P*IW-1:0]  src;
        logic [P*IW-1:0]  dst;
        logic             ph;
    } lb_reg_t;

    lb_reg_t r_q, r_d;

    logic [TW-1:0]   total;
    logic [N-1:0]    giver, taker, surplus2;
    logic [P-1:0]    slot_vld;
    logic [P*IW-1:0] slot_src, slot_dst;
    logic [N-1:0]    send_mask, recv_mask;
    logic            in_trim;

    assign in_trim = (r_q.st == ST_REDIST);

    lb_total #(.N(N), .CW(CW), .TW(TW)) total_i (
        .cnt   (r_q.cnt),
        .total (total)
    );

    lb_classify #(.N(N), .CW(CW)) class_i (
        .cnt      (r_q.cnt),
        .avg      (r_q.avg),
        .redist   (in_trim),
        .giver    (giver),
        .taker    (taker),
        .surplus2 (surplus2)
    );

    lb_pair #(.N(N), .P(P), .IW(IW), .CNTW(CNTW)) pair_i (
        .giver     (giver),
        .taker     (taker),
        .slot_vld  (slot_vld),
        .slot_src  (slot_src),
        .slot_dst  (slot_dst),
        .send_mask (send_mask),
        .recv_mask (recv_mask)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = '0;
        unique case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    r_d.cnt = load_in;
                    r_d.src = '0;
                    r_d.dst = '0;
                    r_d.ph  = 1'b0;
                    r_d.st  = ST_SUM;
                end
            end
            ST_SUM: begin
                r_d.avg = total[LOG2N +: CW];
                r_d.st  = ST_DIST;
            end
            ST_DIST, ST_REDIST: begin
                if (|slot_vld) begin
                    for (int i = 0; i < N; i++) begin
                        if (send_mask[i])
                            r_d.cnt[i*CW +: CW] = r_q.cnt[i*CW +: CW] - 1'b1;
                        else if (recv_mask[i])
                            r_d.cnt[i*CW +: CW] = r_q.cnt[i*CW +: CW] + 1'b1;
                    end
                    r_d.vld = slot_vld;
                    r_d.src = slot_src;
                    r_d.dst = slot_dst;
                    r_d.ph  = in_trim;
                end else if (!in_trim && (|surplus2)) begin
                    r_d.st = ST_REDIST;
                end else begin
                    r_d.st = ST_DONE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign xfer_vld    = r_q.vld;
    assign xfer_src    = r_q.src;
    assign xfer_dst    = r_q.dst;
    assign xfer_redist = r_q.ph;
    assign busy        = (r_q.st == ST_SUM) || (r_q.st == ST_DIST) || (r_q.st == ST_REDIST);
    assign done        = (r_q.st == ST_DONE);
    assign count_out   = r_q.cnt;
    assign avg_out     = r_q.avg;
endmodule

// File: rtl/lb_balancer_chk.sv
module lb_balancer_chk #(
    parameter int N  = 8,
    parameter int CW = 8,
    parameter int P  = N / 2,
    parameter int IW = $clog2(N)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [P-1:0]    xfer_vld,
    input logic [P*IW-1:0] xfer_src,
    input logic [P*IW-1:0] xfer_dst,
    input logic            busy,
    input logic            done,
    input logic [N*CW-1:0] count_out
);
    localparam int TW = CW + $clog2(N);

    logic [TW-1:0] sum_now;
    always_comb begin
        sum_now = '0;
        for (int i = 0; i < N; i++) sum_now = sum_now + TW'(count_out[i*CW +: CW]);
    end

    // R4
    xfer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_vld != '0) |-> busy);

    // R5
    slot_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((xfer_vld + 1'b1) & xfer_vld) == '0);

    // R10
    for (genvar k = 0; k < P; k++) begin : g_slot
        pair_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_vld[k] |-> (xfer_src[k*IW +: IW] != xfer_dst[k*IW +: IW]));
    end

    // R6
    task_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (sum_now == $past(sum_now)));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind lb_balancer lb_balancer_chk #(.N(N), .CW(CW), .P(P), .IW(IW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .xfer_vld  (xfer_vld),
    .xfer_src  (xfer_src),
    .xfer_dst  (xfer_dst),
    .busy      (busy),
    .done      (done),
    .count_out (count_out)
);

// File: tb/lb_balancer_tb.sv
module lb_balancer_tb_top;
    localparam int N  = 8;
    localparam int CW = 8;
    localparam int P  = N / 2;
    localparam int IW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [N*CW-1:0] load_in = '0;
    logic [P-1:0]    xfer_vld;
    logic [P*IW-1:0] xfer_src, xfer_dst;
    logic            xfer_redist, busy, done;
    logic [N*CW-1:0] count_out;
    logic [CW-1:0]   avg_out;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    typedef struct {
        logic [P-1:0]    vld;
        logic [P*IW-1:0] src;
        logic [P*IW-1:0] dst;
        logic            ph;
        logic [N*CW-1:0] cnt;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    lb_balancer #(.N(N), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .load_in(load_in),
        .xfer_vld(xfer_vld), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_redist(xfer_redist), .busy(busy), .done(done),
        .count_out(count_out), .avg_out(avg_out)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // monitor: pop the expected round whenever the design reports one
    always @(negedge clk) begin
        if (rst_n && xfer_vld != '0) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R4 unexpected round", 64'(xfer_vld), 64'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(xfer_vld == it.vld, "R4 slot count", 64'(xfer_vld), 64'(it.vld));
                chk({xfer_src, xfer_dst, xfer_redist} == {it.src, it.dst, it.ph},
                    "R5 R3 R7 R10 pairing",
                    64'({xfer_src, xfer_dst, xfer_redist}), 64'({it.src, it.dst, it.ph}));
                chk(count_out == it.cnt, "R6 counts after round", count_out, it.cnt);
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                chk(1'b0, "watchdog", 64'(cycles), 64'd0);
                finish_run();
            end
        end
    end

    // driver: build the expected rounds from the requirements, then run
    task automatic run_case(input logic [N*CW-1:0] loads, input string tag, input bit poke);
        int c[N];
        int tot = 0;
        int avg;
        bit trim = 1'b0;
        logic [N*CW-1:0] fin;
        for (int i = 0; i < N; i++) begin
            c[i] = int'(loads[i*CW +: CW]);
            tot += c[i];
        end
        avg = tot / N;
        for (int guard = 0; guard < 4096; guard++) begin
            int gi[$];
            int ti[$];
            int bw;
            bit big = 1'b0;
            for (int i = 0; i < N; i++) begin
                int df = c[i] - avg;
                if (df > 1) big = 1'b1;
                if (trim ? (df > 1) : (df > 0)) gi.push_back(i);
                if (trim ? (df == 0) : (df < 0)) ti.push_back(i);
            end
            bw = (gi.size() < ti.size()) ? gi.size() : ti.size();
            if (bw == 0) begin
                if (!trim && big) trim = 1'b1;
                else break;
            end else begin
                item_t it;
                it.vld = '0; it.src = '0; it.dst = '0; it.ph = trim;
                for (int k = 0; k < bw; k++) begin
                    it.vld[k] = 1'b1;
                    it.src[k*IW +: IW] = IW'(gi[k]);
                    it.dst[k*IW +: IW] = IW'(ti[k]);
                    c[gi[k]]--;
                    c[ti[k]]++;
                end
                for (int i = 0; i < N; i++) it.cnt[i*CW +: CW] = CW'(c[i]);
                sb.push_back(it);
            end
        end
        for (int i = 0; i < N; i++) fin[i*CW +: CW] = CW'(c[i]);

        @(negedge clk);
        load_in = loads;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            load_in = ~loads;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(count_out == fin, {"R8 final counts ", tag}, count_out, fin);
        chk(avg_out == CW'(avg), {"R2 average ", tag}, 64'(avg_out), 64'(avg));
        chk(sb.size() == 0, {"R4 missing rounds ", tag}, 64'(sb.size()), 64'd0);
        chk(!busy, {"R8 busy low at end ", tag}, 64'(busy), 64'd0);
        sb.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0 && busy == 1'b0, "R1 done/busy in reset", 64'({done, busy}), 64'd0);
        chk(xfer_vld == '0, "R1 slots idle in reset", 64'(xfer_vld), 64'd0);
        chk(count_out == '0, "R1 counts in reset", count_out, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R1 idle after reset", 64'({done, busy}), 64'd0);

        // node i at bits [i*8 +: 8]; node 0 is the lowest byte
        run_case({8'd6, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd10}, "spread two givers", 1'b0);
        run_case({8{8'd5}}, "already even", 1'b0);
        run_case({8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd7}, "R7 trim only", 1'b0);
        run_case({8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd255, 8'd255}, "max counts", 1'b0);
        run_case({8'd6, 8'd2, 8'd8, 8'd0, 8'd4, 8'd1, 8'd9, 8'd3}, "mixed", 1'b0);
        run_case({8'd1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0}, "single extra", 1'b0);
        run_case({8'd0, 8'd12, 8'd0, 8'd3, 8'd0, 8'd0, 8'd1, 8'd14}, "R9 start while busy", 1'b1);
        run_case('0, "all zero", 1'b0);
        finish_run();
    end
endmodule